// File: doc/BRIEF.md
# Int8 SIMD Dot-Product Chain

This block computes signed 8-bit inner products for quantized matrix-vector work. Each input token carries two weight bytes and two activation bytes, which are two neighbouring vector elements. A token enters a linear chain of twelve stages. Adjacent stages are linked only by small point-to-point FIFOs. The head stage forms two independent signed 8x8 products and widens each to a 24-bit partial sum. The middle stages carry these pairs forward in a fixed order. The tail stage adds each incoming pair into two 24-bit lane accumulators in a single two-way add.

A vector has 32 elements, which is 16 tokens, delivered as two bursts of eight tokens (16 elements each). The sender marks the final token of the second burst with a last flag. When the tail stage takes that token, it adds the two lane totals into one 24-bit result and raises a result-valid flag. It then clears its accumulators for the next vector.

The output has a ready input. When the result is not taken, the tail stage holds the next vector's last token. The link FIFOs then fill and back-pressure reaches the input. With no back-pressure, the latency from the last token to the result is fixed.

Top module: `dpc_int8_chain`

## Requirements
- R1: After reset is released, `res_valid` is 0 and `in_ready` is 1.
- R2: Element 2k of a vector travels in bits [7:0] of `in_w`/`in_a` of token k, and element 2k+1 travels in bits [15:8]. Each byte is a signed two's-complement value. Each lane multiplies its own weight and activation pair and accumulates into its own 24-bit partial sum.
- R3: `res_data` equals the sum of all 32 signed weight-activation products of the vector, as a 24-bit two's-complement value (both lane totals added).
- R4: The lane accumulators are cleared once the last token has been accumulated, so each result depends only on its own vector. A reset in the middle of a vector discards the partial vector entirely.
- R5: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and `res_data` does not change.
- R6: With `res_ready` held at 1, `res_valid` rises exactly 12 clock edges after the edge that accepts the last token of a vector (one edge per stage).
- R7: When output back-pressure fills the chain, `in_ready` falls. No token is lost or duplicated, and every result is delivered in input order once `res_ready` returns.
- R8: A vector is exactly 16 tokens (two bursts of 8 tokens). `in_last` is 1 on the 16th token only.
- R9: Vectors may be sent back to back at one token per cycle with no gap. Each yields its own correct result, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input token present |
| in_ready | output | 1 | Chain can accept a token this cycle |
| in_w | input | 16 | Two signed weight bytes (lane 1 high, lane 0 low) |
| in_a | input | 16 | Two signed activation bytes (lane 1 high, lane 0 low) |
| in_last | input | 1 | Token is the final one of the vector |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_data | output | 24 | Signed 24-bit inner product |

## Verification
Single vectors are sent with each of these patterns:
- Constant maximum-positive operands.
- Constant minimum-negative operands.
- Mixed-sign extreme operands, which separate signed from unsigned multiplication.
- A pattern with every lane-1 weight zero, which exposes lane crossing or a lost lane.
- Unequal pseudo-random weight and activation sequences, which expose swapped operands or element order.
- Alternating-sign weights that cancel to zero.

Back-to-back vectors show that the accumulators clear exactly at the last token. A long result stall, with three more vectors queued behind it, forces the input to stall and shows that tokens are neither lost nor repeated. A reset in the middle of a vector shows that the partial sums are dropped.

// File: rtl/dpc_pkg.sv
// Shared widths and token types for the int8 dot-product chain.
// Assumes a fixed two-way SIMD organisation of signed 8-bit lanes.
package dpc_pkg;
    localparam int LANES  = 2;
    localparam int ELEM_W = 8;
    localparam int PROD_W = 2 * ELEM_W;
    localparam int PSUM_W = 24;

    // Token accepted at the chain input: one element per lane.
    typedef struct packed {
        logic                          last;
        logic [LANES-1:0][ELEM_W-1:0]  w;
        logic [LANES-1:0][ELEM_W-1:0]  a;
    } in_tok_t;

    // Token carried between stages: one 24-bit partial sum per lane.
    typedef struct packed {
        logic                          last;
        logic [LANES-1:0][PSUM_W-1:0]  p;
    } psum_tok_t;
endpackage

// File: rtl/dpc_fifo.sv
// Point-to-point link FIFO between two chain stages.
// Assumes the writer pushes only when not full and the reader pops only
// when not empty; read data is the head entry, valid while not empty.
module dpc_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    output logic             full,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;

    // Storage write; data needs no reset because cnt gates its use.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == PTR_MAX) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == PTR_MAX) ? '0 : rp + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign rdata = mem[rp];

    // R7: the stage feeding this link never writes into a full FIFO.
    a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R7: the stage draining this link never reads an empty FIFO.
    a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R7: occupancy stays within the storage.
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
endmodule

// File: rtl/dpc_mac.sv
// Head stage: two-way SIMD signed 8x8 multiply, each product widened
// to a 24-bit partial sum. Purely combinational; the following link
// FIFO provides the stage register.
module dpc_mac
    import dpc_pkg::*;
(
    input  in_tok_t   tok_in,
    output psum_tok_t tok_out
);
    // Per-lane signed product, sign-extended into the partial-sum width.
    always_comb begin
        tok_out.last = tok_in.last;
        for (int l = 0; l < LANES; l++) begin
            logic signed [PROD_W-1:0] prod;
            prod = $signed(tok_in.w[l]) * $signed(tok_in.a[l]);
            tok_out.p[l] = {{(PSUM_W - PROD_W){prod[PROD_W-1]}}, prod};
        end
    end
endmodule

// File: rtl/dpc_accum.sv
// Tail stage: two-way 24-bit accumulation of lane partial sums, and a
// final add of the lane totals into one result per vector.
// Assumes every vector is TOKS tokens long with last on the final one.
module dpc_accum
    import dpc_pkg::*;
#(
    parameter int TOKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  psum_tok_t         tok,
    output logic              tok_take,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [PSUM_W-1:0] res_data
);
    localparam int CW = (TOKS > 1) ? $clog2(TOKS) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(TOKS - 1);

    logic [LANES-1:0][PSUM_W-1:0] acc;
    logic [LANES-1:0][PSUM_W-1:0] nxt;
    logic [PSUM_W-1:0]            total;
    logic [CW-1:0]                cnt;

    // A last token waits while an untaken result still occupies the output.
    assign tok_take = tok_valid && !(tok.last && res_valid && !res_ready);

    // Two-way lane add, then the lane totals folded into one sum.
    always_comb begin
        total = '0;
        for (int l = 0; l < LANES; l++) begin
            nxt[l] = acc[l] + tok.p[l];
            total  = total + nxt[l];
        end
    end

    // Accumulator, token position and result register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            cnt       <= '0;
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            if (res_valid && res_ready) res_valid <= 1'b0;
            if (tok_take) begin
                if (tok.last) begin
                    acc       <= '0;
                    cnt       <= '0;
                    res_valid <= 1'b1;
                    res_data  <= total;
                end else begin
                    acc <= nxt;
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R4: accumulators start from zero after a vector completes.
    a_r4_clear_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_take && tok.last) |=> (acc == '0));
    // R5: an untaken result is held unchanged.
    a_r5_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));
    // R8: the last flag arrives on the final token of the vector.
    a_r8_last_position: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_take && tok.last) |-> (cnt == LAST_IDX));
    // R8: a vector never runs past its token count without a last flag.
    a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_take && !tok.last) |-> (cnt != LAST_IDX));
endmodule

// File: rtl/dpc_int8_chain.sv
// Top of the int8 dot-product chain: head multiply stage, relay stages
// and the tail accumulator, every neighbour pair joined by a link FIFO.
// Assumes NUM_STAGES >= 3 and VEC_ELEMS a multiple of the lane count.
module dpc_int8_chain
    import dpc_pkg::*;
#(
    parameter int NUM_STAGES = 12,
    parameter int FIFO_DEPTH = 2,
    parameter int VEC_ELEMS  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [LANES*ELEM_W-1:0]   in_w,
    input  logic [LANES*ELEM_W-1:0]   in_a,
    input  logic                      in_last,
    output logic                      res_valid,
    input  logic                      res_ready,
    output logic [PSUM_W-1:0]         res_data
);
    localparam int TOKS  = VEC_ELEMS / LANES;
    localparam int IN_W  = $bits(in_tok_t);
    localparam int PS_W  = $bits(psum_tok_t);
    localparam int LAST  = NUM_STAGES - 1;

    // Link 0 carries raw operand tokens into the head stage.
    in_tok_t          in_tok, head_tok;
    logic [IN_W-1:0]  f0_rdata;
    logic             f0_full, f0_empty, f0_pop, f0_push;

    // Links 1..LAST carry partial-sum tokens.
    logic [LAST:1]    lk_push, lk_pop, lk_full, lk_empty;
    logic [PS_W-1:0]  lk_wdata [LAST:1];
    logic [PS_W-1:0]  lk_rdata [LAST:1];
    psum_tok_t        mac_out, tail_tok;
    logic             tail_take;

    assign in_tok   = '{last: in_last, w: in_w, a: in_a};
    assign in_ready = !f0_full;
    assign f0_push  = in_valid && !f0_full;

    dpc_fifo #(.WIDTH(IN_W), .DEPTH(FIFO_DEPTH)) u_link0 (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (f0_push),
        .wdata (in_tok),
        .full  (f0_full),
        .pop   (f0_pop),
        .rdata (f0_rdata),
        .empty (f0_empty)
    );

    assign head_tok = in_tok_t'(f0_rdata);

    dpc_mac u_head (
        .tok_in  (head_tok),
        .tok_out (mac_out)
    );

    // Head stage moves a token when its input has one and its output has room.
    assign f0_pop      = !f0_empty && !lk_full[1];
    assign lk_push[1]  = f0_pop;
    assign lk_wdata[1] = mac_out;

    genvar k;
    generate
        for (k = 1; k <= LAST; k++) begin : g_link
            dpc_fifo #(.WIDTH(PS_W), .DEPTH(FIFO_DEPTH)) u_link (
                .clk   (clk),
                .rst_n (rst_n),
                .push  (lk_push[k]),
                .wdata (lk_wdata[k]),
                .full  (lk_full[k]),
                .pop   (lk_pop[k]),
                .rdata (lk_rdata[k]),
                .empty (lk_empty[k])
            );
        end
        for (k = 1; k < LAST; k++) begin : g_relay
            // Relay stage: forward the head token when the next link has room.
            assign lk_pop[k]     = !lk_empty[k] && !lk_full[k+1];
            assign lk_push[k+1]  = lk_pop[k];
            assign lk_wdata[k+1] = lk_rdata[k];
        end
    endgenerate

    assign tail_tok     = psum_tok_t'(lk_rdata[LAST]);
    assign lk_pop[LAST] = tail_take;

    dpc_accum #(.TOKS(TOKS)) u_tail (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_valid (!lk_empty[LAST]),
        .tok       (tail_tok),
        .tok_take  (tail_take),
        .res_valid (res_valid),
        .res_ready (res_ready),
        .res_data  (res_data)
    );
endmodule

// File: tb/dpc_int8_chain_tb_top.sv
module dpc_int8_chain_tb_top;
    localparam int STAGES = 12;
    localparam int NTAB   = 6;
    // Each entry: pattern kind [23:16], weight seed [15:8], activation seed [7:0].
    localparam logic [23:0] VEC_TAB [NTAB] = '{
        24'h00_00_00, 24'h01_00_00, 24'h02_00_00,
        24'h03_05_00, 24'h04_25_3B, 24'h05_00_77
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_w = '0;
    logic [15:0] in_a = '0;
    logic        in_last = 1'b0;
    logic        res_valid;
    logic        res_ready = 1'b1;
    logic [23:0] res_data;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_acc_cyc = 0;
    int n_got = 0;
    logic [23:0] got_data [64];
    int          got_cyc  [64];
    bit saw_stall = 1'b0;

    always #4 clk = ~clk;

    dpc_int8_chain dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_w(in_w), .in_a(in_a), .in_last(in_last),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Result and stall monitor, sampled after the falling edge.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (res_valid && res_ready && n_got < 64) begin
                got_data[n_got] = res_data;
                got_cyc[n_got]  = cyc;
                n_got++;
            end
            if (in_valid && !in_ready) saw_stall = 1'b1;
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic signed [7:0] elem(input int kind, input int seed,
                                                input int idx, input bit is_w);
        logic signed [7:0] v;
        case (kind)
            0: v = 8'sd127;
            1: v = -8'sd128;
            2: v = is_w ? -8'sd128 : 8'sd127;
            3: v = (is_w && (idx % 2 == 1)) ? 8'sd0 : 8'(idx * seed + 3);
            4: v = 8'(idx * seed + (is_w ? 7 : 13)) ^ 8'h5A;
            default: v = is_w ? ((idx % 2 == 1) ? -8'sd100 : 8'sd100) : 8'(seed);
        endcase
        return v;
    endfunction

    // Reference: exact signed sum of products, kept to 24 bits (R3).
    function automatic logic [23:0] exp_dot(input int kind, input int sw, input int sa);
        int s = 0;
        for (int i = 0; i < 32; i++)
            s += int'(elem(kind, sw, i, 1'b1)) * int'(elem(kind, sa, i, 1'b0));
        return s[23:0];
    endfunction

    task automatic send_tok(input logic [15:0] w, input logic [15:0] a, input logic last);
        logic ok;
        in_valid = 1'b1; in_w = w; in_a = a; in_last = last;
        forever begin
            ok = in_ready;
            @(negedge clk);
            if (ok) break;
        end
        last_acc_cyc = cyc;
        in_valid = 1'b0;
    endtask

    // Element 2t in the low byte, 2t+1 in the high byte (R2).
    task automatic send_vec(input int kind, input int sw, input int sa);
        for (int t = 0; t < 16; t++)
            send_tok({elem(kind, sw, 2*t+1, 1'b1), elem(kind, sw, 2*t, 1'b1)},
                     {elem(kind, sa, 2*t+1, 1'b0), elem(kind, sa, 2*t, 1'b0)},
                     t == 15);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_results(input int target);
        while (n_got < target) @(negedge clk);
    endtask

    initial begin
        int n0;
        do_reset();
        check("R1", "res_valid after reset", 32'(res_valid), 32'd0);
        check("R1", "in_ready after reset", 32'(in_ready), 32'd1);

        // Table walk: value (R2, R3) and fixed latency (R6).
        res_ready = 1'b1;
        for (int e = 0; e < NTAB; e++) begin
            n0 = n_got;
            send_vec(int'(VEC_TAB[e][23:16]), int'(VEC_TAB[e][15:8]), int'(VEC_TAB[e][7:0]));
            wait_results(n0 + 1);
            check("R3", $sformatf("dot kind %0d", VEC_TAB[e][23:16]), 32'(got_data[n0]),
                  32'(exp_dot(int'(VEC_TAB[e][23:16]), int'(VEC_TAB[e][15:8]), int'(VEC_TAB[e][7:0]))));
            check("R6", "latency", 32'(got_cyc[n0] - last_acc_cyc), 32'(STAGES));
        end

        // R9 / R4: back-to-back vectors with no gap.
        n0 = n_got;
        send_vec(4, 17, 99);
        send_vec(0, 0, 0);
        send_vec(3, 9, 0);
        wait_results(n0 + 3);
        check("R9", "b2b first",  32'(got_data[n0]),     32'(exp_dot(4, 17, 99)));
        check("R4", "b2b second", 32'(got_data[n0 + 1]), 32'(exp_dot(0, 0, 0)));
        check("R9", "b2b third",  32'(got_data[n0 + 2]), 32'(exp_dot(3, 9, 0)));

        // R5 / R7: result stall and back-pressure.
        res_ready = 1'b0;
        saw_stall = 1'b0;
        n0 = n_got;
        send_vec(2, 0, 0);
        repeat (20) @(negedge clk);
        check("R5", "held valid", 32'(res_valid), 32'd1);
        check("R5", "held data",  32'(res_data),  32'(exp_dot(2, 0, 0)));
        fork
            begin
                send_vec(4, 3, 200);
                send_vec(5, 0, 41);
                send_vec(4, 250, 7);
            end
            begin
                repeat (120) @(negedge clk);
                res_ready = 1'b1;
            end
        join
        wait_results(n0 + 4);
        check("R7", "in_ready fell", 32'(saw_stall), 32'd1);
        check("R7", "stalled A", 32'(got_data[n0]),     32'(exp_dot(2, 0, 0)));
        check("R7", "stalled B", 32'(got_data[n0 + 1]), 32'(exp_dot(4, 3, 200)));
        check("R7", "stalled C", 32'(got_data[n0 + 2]), 32'(exp_dot(5, 0, 41)));
        check("R7", "stalled D", 32'(got_data[n0 + 3]), 32'(exp_dot(4, 250, 7)));

        // R4: reset in the middle of a vector drops the partial sums.
        for (int t = 0; t < 5; t++) send_tok(16'h7F7F, 16'h7F7F, 1'b0);
        repeat (4) @(negedge clk);
        do_reset();
        check("R1", "in_ready after mid reset", 32'(in_ready), 32'd1);
        n0 = n_got;
        send_vec(4, 61, 5);
        wait_results(n0 + 1);
        repeat (20) @(negedge clk);
        check("R4", "fresh vector after reset", 32'(got_data[n0]), 32'(exp_dot(4, 61, 5)));
        check("R4", "single result after reset", 32'(n_got - n0), 32'd1);

        summary();
        $finish;
    end
endmodule